// File: doc/BRIEF.md
# Multi-Domain Exclusive Access Monitor

This block sits beside the transfer path of a multi-port memory controller and decides the outcome of exclusive read/write pairs. Each cycle it sees at most one granted transfer, tagged with a domain number. Ports that belong to one master, such as its separate read and write ports, carry the same domain number and therefore share one reservation. There are four reservation slots, one per domain value, so four masters can each hold a reservation on a different address at the same time.

An exclusive read opens a reservation for its domain. An exclusive write from that domain succeeds only while the reservation is open and its address matches. Any write that reaches memory closes every reservation on the granule it touches. Exclusive intent is only honoured from wide (64-bit) ports. A request from a narrow port is handled as an ordinary transfer. One cycle after each transfer the block returns a response that says whether the write may proceed to memory and, for exclusive transfers, whether the exclusive succeeded.

Top module: `excl_monitor`

## Requirements
- R1: After reset no response is signalled, and every reservation is closed, so an exclusive write issued first fails.
- R2: Every accepted transfer (`req_vld_i`=1) produces exactly one response cycle (`rsp_vld_o`=1) on the next clock, and an idle cycle produces none.
- R3: An exclusive read from a wide port opens the reservation of its domain with the address aligned down to the transfer size (size code n means 2^n bytes) and reports exclusive-okay.
- R4: An exclusive write from a wide port reports exclusive-okay and commits (`rsp_commit_o`=1) when its domain's reservation is open and its size-aligned address equals the stored address. Otherwise it reports exclusive-fail, and the write does not commit and closes no other domain's reservation.
- R5: An exclusive write closes its own domain's reservation whether it succeeds or fails, so a repeat of the same exclusive write fails.
- R6: A committed write from any domain closes every reservation whose stored address lies in the same 8-byte granule (address bits above bit 2 equal). A write to a different granule leaves the reservation open.
- R7: The four domains hold independent reservations. Four exclusive pairs to four addresses, interleaved in any order, all succeed.
- R8: A request from a narrow port (`req_wide_i`=0) with the exclusive bit set is handled as non-exclusive. It reports neither exclusive-okay nor exclusive-fail, a read opens no reservation, and a write commits.
- R9: A plain read changes no reservation and reports no commit, exclusive-okay or exclusive-fail.
- R10: A plain write always commits and never reports exclusive-okay or exclusive-fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_vld_i | input | 1 | A granted transfer is present this cycle |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_excl_i | input | 1 | Extended protection bit requesting exclusive access |
| req_wide_i | input | 1 | Transfer comes from a 64-bit port |
| req_dom_i | input | DOM_W (2) | Domain number of the requester |
| req_addr_i | input | ADDR_W (32) | Byte address |
| req_size_i | input | 3 | Transfer size code, 2^n bytes |
| rsp_vld_o | output | 1 | Response for the previous cycle's transfer |
| rsp_commit_o | output | 1 | Write may be performed in memory |
| rsp_xok_o | output | 1 | Exclusive transfer succeeded |
| rsp_xfail_o | output | 1 | Exclusive write failed |

## Verification
The bench aims at the cases where a careless monitor goes wrong. A repeated exclusive write would wrongly succeed if the monitor were not cleared after a failed or passed write. A byte write to another word in a reserved granule would leave a stale reservation open if matching used the full address. An exclusive write at an unaligned address inside the reserved unit tests alignment: without it the write fails, and with a too-coarse compare a wrong-size write passes. Narrow-port exclusives and failed exclusives from a foreign domain are driven to catch a design that opens a reservation from a narrow port or lets a suppressed write close other domains' reservations. Long random runs over a few colliding addresses then compare every response against the behavioural model.

// File: rtl/excl_monitor_pkg.sv
package excl_monitor_pkg;
  typedef struct packed {
    logic vld;
    logic commit;
    logic xok;
    logic xfail;
  } excl_rsp_t;
endpackage

// File: rtl/excl_mon_entry.sv
module excl_mon_entry #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
    end else if (set_i) begin
      vld_o  <= 1'b1;
      addr_o <= addr_i;
    end else if (clr_i) begin
      vld_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/excl_mon_rsp.sv
module excl_mon_rsp
  import excl_monitor_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  excl_rsp_t rsp_d_i,
  output excl_rsp_t rsp_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsp_q_o <= '0;
    else         rsp_q_o <= rsp_d_i;
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_monitor_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_DOM  = 4,
  parameter int GRAN_LSB = 3,
  localparam int DOM_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_vld_i,
  input  logic              req_wr_i,
  input  logic              req_excl_i,
  input  logic              req_wide_i,
  input  logic [DOM_W-1:0]  req_dom_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_size_i,
  output logic              rsp_vld_o,
  output logic              rsp_commit_o,
  output logic              rsp_xok_o,
  output logic              rsp_xfail_o
);
  logic              excl;
  logic [ADDR_W-1:0] size_mask, addr_al;
  logic [NUM_DOM-1:0] mon_vld, dom_hit, addr_eq, gran_eq, set, clr;
  logic [ADDR_W-1:0] mon_addr [NUM_DOM];
  logic              pass, commit;
  excl_rsp_t         rsp_d, rsp_q;

  // narrow ports never take part in exclusive tracking
  assign excl      = req_excl_i & req_wide_i;
  assign size_mask = {ADDR_W{1'b1}} << req_size_i;
  assign addr_al   = req_addr_i & size_mask;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_mon
    assign dom_hit[d] = (req_dom_i == DOM_W'(d));
    assign addr_eq[d] = (mon_addr[d] == addr_al);
    assign gran_eq[d] = (mon_addr[d][ADDR_W-1:GRAN_LSB] == req_addr_i[ADDR_W-1:GRAN_LSB]);
    assign set[d]     = req_vld_i & ~req_wr_i & excl & dom_hit[d];
    assign clr[d]     = (req_vld_i & req_wr_i & excl & dom_hit[d]) | (commit & gran_eq[d]);

    excl_mon_entry #(.ADDR_W(ADDR_W)) u_entry (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set[d]),
      .clr_i  (clr[d]),
      .addr_i (addr_al),
      .vld_o  (mon_vld[d]),
      .addr_o (mon_addr[d])
    );
  end

  assign pass   = |(dom_hit & mon_vld & addr_eq);
  assign commit = req_vld_i & req_wr_i & (~excl | pass);

  always_comb begin
    rsp_d.vld    = req_vld_i;
    rsp_d.commit = commit;
    rsp_d.xok    = req_vld_i & excl & (~req_wr_i | pass);
    rsp_d.xfail  = req_vld_i & excl & req_wr_i & ~pass;
  end

  excl_mon_rsp u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rsp_d_i (rsp_d),
    .rsp_q_o (rsp_q)
  );

  assign rsp_vld_o    = rsp_q.vld;
  assign rsp_commit_o = rsp_q.commit;
  assign rsp_xok_o    = rsp_q.xok;
  assign rsp_xfail_o  = rsp_q.xfail;
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int DOM_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_vld_i,
  input logic             req_wr_i,
  input logic             req_excl_i,
  input logic             req_wide_i,
  input logic [DOM_W-1:0] req_dom_i,
  input logic             rsp_vld_o,
  input logic             rsp_commit_o,
  input logic             rsp_xok_o,
  input logic             rsp_xfail_o
);
  p_rsp_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i |=> rsp_vld_o);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_vld_i |=> !rsp_vld_o && !rsp_commit_o && !rsp_xok_o && !rsp_xfail_o);
  p_fail_no_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_xfail_o |-> !rsp_commit_o && !rsp_xok_o);
  p_repeat_fails_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && req_wr_i && req_excl_i && req_wide_i &&
     $past(req_vld_i && req_wr_i && req_excl_i && req_wide_i) &&
     req_dom_i == $past(req_dom_i)) |=> rsp_xfail_o);
  p_narrow_plain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && !req_wide_i) |=> !rsp_xok_o && !rsp_xfail_o);
  p_read_no_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && !req_wr_i && !req_excl_i) |=> !rsp_commit_o && !rsp_xok_o);
  p_plain_wr_commits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && req_wr_i && !(req_excl_i && req_wide_i)) |=> rsp_commit_o && !rsp_xfail_o);
endmodule

bind excl_monitor excl_monitor_chk #(.DOM_W(DOM_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_vld_i    (req_vld_i),
  .req_wr_i     (req_wr_i),
  .req_excl_i   (req_excl_i),
  .req_wide_i   (req_wide_i),
  .req_dom_i    (req_dom_i),
  .rsp_vld_o    (rsp_vld_o),
  .rsp_commit_o (rsp_commit_o),
  .rsp_xok_o    (rsp_xok_o),
  .rsp_xfail_o  (rsp_xfail_o)
);

// File: tb/tb_excl_monitor.sv
`timescale 1ns/1ps
module tb_excl_monitor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_vld_i = 1'b0, req_wr_i = 1'b0, req_excl_i = 1'b0, req_wide_i = 1'b0;
  logic [1:0]  req_dom_i = '0;
  logic [31:0] req_addr_i = '0;
  logic [2:0]  req_size_i = '0;
  logic        rsp_vld_o, rsp_commit_o, rsp_xok_o, rsp_xfail_o;

  int n_chk = 0, n_fail = 0;
  bit          m_vld [4];
  logic [31:0] m_adr [4];

  always #2.5 clk_i = ~clk_i;

  excl_monitor dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_vld_i(req_vld_i), .req_wr_i(req_wr_i),
    .req_excl_i(req_excl_i), .req_wide_i(req_wide_i), .req_dom_i(req_dom_i),
    .req_addr_i(req_addr_i), .req_size_i(req_size_i), .rsp_vld_o(rsp_vld_o),
    .rsp_commit_o(rsp_commit_o), .rsp_xok_o(rsp_xok_o), .rsp_xfail_o(rsp_xfail_o)
  );

  task automatic cmp(string tag, logic [3:0] exp);
    logic [3:0] act;
    act = {rsp_vld_o, rsp_commit_o, rsp_xok_o, rsp_xfail_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {vld,commit,xok,xfail} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive one cycle at negedge, model it, compare after the next posedge
  task automatic xfer(string tag, bit vld, bit wr, bit ex, bit wide,
                      int dom, logic [31:0] addr, int size);
    logic [31:0] al;
    bit x, ok, cm;
    logic [3:0] exp;
    req_vld_i = vld; req_wr_i = wr; req_excl_i = ex; req_wide_i = wide;
    req_dom_i = 2'(dom); req_addr_i = addr; req_size_i = 3'(size);
    al = (addr >> size) << size;
    x  = ex && wide;
    ok = m_vld[dom] && (m_adr[dom] == al);
    cm = vld && wr && (!x || ok);
    exp = {vld, cm, vld && x && (!wr || ok), vld && x && wr && !ok};
    if (vld && !wr && x) begin m_vld[dom] = 1; m_adr[dom] = al; end
    if (vld && wr && x) m_vld[dom] = 0;
    if (cm) for (int d = 0; d < 4; d++)
      if ((m_adr[d] >> 3) == (addr >> 3)) m_vld[d] = 0;
    @(posedge clk_i);
    @(negedge clk_i);
    cmp(tag, exp);
  endtask

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int d = 0; d < 4; d++) begin m_vld[d] = 0; m_adr[d] = '0; end
    repeat (3) @(negedge clk_i);
    cmp("R1 reset", 4'b0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp("R2 idle", 4'b0000);
    xfer("R1 first excl write", 1, 1, 1, 1, 0, 32'h100, 3);
    // R3 / R4 / R5 basic pair
    xfer("R3 excl read", 1, 0, 1, 1, 0, 32'h100, 3);
    xfer("R4 excl write pass", 1, 1, 1, 1, 0, 32'h100, 3);
    xfer("R5 repeat fails", 1, 1, 1, 1, 0, 32'h100, 3);
    // R3 alignment
    xfer("R3 read word", 1, 0, 1, 1, 1, 32'h104, 2);
    xfer("R4 misaligned half", 1, 1, 1, 1, 1, 32'h106, 1);
    xfer("R3 reread", 1, 0, 1, 1, 1, 32'h104, 2);
    xfer("R3 unaligned word match", 1, 1, 1, 1, 1, 32'h105, 2);
    // R7 four domains interleaved
    for (int d = 0; d < 4; d++) xfer("R7 read", 1, 0, 1, 1, d, 32'h1000 + d*32'h100, 3);
    for (int d = 3; d >= 0; d--) xfer("R7 write", 1, 1, 1, 1, d, 32'h1000 + d*32'h100, 3);
    // R6 granule clear
    xfer("R6 read", 1, 0, 1, 1, 2, 32'h300, 2);
    xfer("R10 plain byte write", 1, 1, 0, 1, 0, 32'h307, 0);
    xfer("R6 cleared", 1, 1, 1, 1, 2, 32'h300, 2);
    xfer("R6 read", 1, 0, 1, 1, 3, 32'h400, 3);
    xfer("R6 other granule", 1, 1, 0, 1, 0, 32'h408, 3);
    xfer("R6 still open", 1, 1, 1, 1, 3, 32'h400, 3);
    // R8 narrow ports
    xfer("R8 narrow excl read", 1, 0, 1, 0, 0, 32'h500, 3);
    xfer("R8 no reservation", 1, 1, 1, 1, 0, 32'h500, 3);
    xfer("R8 wide read", 1, 0, 1, 1, 1, 32'h600, 2);
    xfer("R8 narrow excl write", 1, 1, 1, 0, 1, 32'h600, 2);
    xfer("R8 cleared by narrow", 1, 1, 1, 1, 1, 32'h600, 2);
    // R9 plain read
    xfer("R9 excl read", 1, 0, 1, 1, 0, 32'h700, 2);
    xfer("R9 plain read", 1, 0, 0, 1, 0, 32'h700, 2);
    xfer("R2 idle", 0, 0, 0, 0, 0, 32'h0, 0);
    xfer("R9 still open", 1, 1, 1, 1, 0, 32'h700, 2);
    // R4 failed exclusive from a foreign domain leaves others open
    xfer("R4 read", 1, 0, 1, 1, 0, 32'h800, 3);
    xfer("R4 foreign fail", 1, 1, 1, 1, 1, 32'h800, 3);
    xfer("R4 owner passes", 1, 1, 1, 1, 0, 32'h800, 3);
    // random mix over colliding addresses
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom;
      xfer("R4 random", r[0] | r[1], r[2], r[3] | r[4], r[5] | r[6], int'(r[8:7]),
           32'h2000 + 32'(r[12:9]) * 4, int'(r[14:13]));
    end
    xfer("R2 idle", 0, 0, 0, 0, 0, 32'h0, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule